// File: doc/BRIEF.md
# Flash Interrupt Status Register

This block holds the interrupt status of a flash memory controller. The internal operation sequencer reports each finished command by pulsing a completion strobe together with the 16-bit command code. The block sorts the code into one of three completion classes: load/read, program/write and erase-class. It keeps one sticky flag per class, plus a fourth flag that records that a reset has taken place. A separate strobe reports a buffer load or the end of boot, and it counts as a load completion.

The four source flags are combined into a master bit. The master bit drives an external interrupt pin, and a configuration input chooses the active level of that pin. The host reads the whole 16-bit word. The host acknowledges an event by writing zero to its flag. Cold and warm/hot reset requests load two different default words. The register sits behind a simple one-cycle register write port, and the read value is always present on its output.

Top module: `flash_irq_status`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `rd_data` reads 8080h, which is the cold default.
- R2: Bit 7 (load flag) becomes 1 on the clock edge at which `done_vld` is high with `done_cmd` equal to 0000h or 0013h, or at which `load_done` is high.
- R3: Bit 6 (program flag) becomes 1 on an edge at which `done_vld` is high with `done_cmd` equal to 0080h, 001Ah or 001Bh.
- R4: Bit 5 (erase-class flag) becomes 1 on an edge at which `done_vld` is high with `done_cmd` equal to 0023h, 002Ah, 002Ch, 0065h or 0071h.
- R5: A completion with any other command code leaves `rd_data` unchanged.
- R6: A write with `wr_en` high and a 0 at bit 7, 6, 5 or 4 of `wr_data` clears that flag. A 1 in that position leaves the flag as it was.
- R7: Bits 14 to 8 and bits 3 to 0 always read 0, whatever is written to them.
- R8: A `cold_req` pulse loads 8080h. A `warm_req` pulse alone loads 8010h, so bit 4 (reset flag) reads 1. When both arrive in the same cycle, cold wins.
- R9: Bit 15 equals the OR of bits 7 to 4. Writing 0 to bit 15 has no effect while any of those bits is set.
- R10: `int_pin` equals `int_pol` while bit 15 is 1, and equals the inverse of `int_pol` while bit 15 is 0.
- R11: When a completion event and a clearing write hit the same flag in the same cycle, the flag is set.
- R12: A reset request overrides any completion event and any host write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; applies the cold default |
| done_vld | input | 1 | Command completion strobe |
| done_cmd | input | 16 | Code of the command that completed |
| load_done | input | 1 | Buffer load or boot finished |
| cold_req | input | 1 | Cold reset request, one cycle |
| warm_req | input | 1 | Warm/hot reset request, one cycle |
| wr_en | input | 1 | Host register write strobe |
| wr_data | input | 16 | Host write data |
| int_pol | input | 1 | Interrupt pin active level |
| rd_data | output | 16 | Register read value |
| int_pin | output | 1 | External interrupt pin |

## Verification
The assertions take for granted that `done_cmd` carries meaning only while `done_vld` is high. They also take for granted that all inputs are synchronous to `clk`, with the reset requests arriving as single-cycle strobes. The bench drives every input on the falling edge and holds each value for one full cycle. It draws command codes both from the listed sets and from random 16-bit values. Reset requests are kept rare, so that the flags have time to build up between them.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int REG_W      = 16;
  localparam int NUM_SRC    = 4;
  localparam int SRC_LSB    = 4;
  localparam int MASTER_BIT = 15;

  // source index inside the flag vector
  localparam int IDX_RST   = 0;
  localparam int IDX_ERASE = 1;
  localparam int IDX_PROG  = 2;
  localparam int IDX_LOAD  = 3;

  localparam logic [NUM_SRC-1:0] COLD_DFLT = 4'b1000;
  localparam logic [NUM_SRC-1:0] WARM_DFLT = 4'b0001;

  function automatic logic is_load_code(input logic [REG_W-1:0] c);
    return (c == 16'h0000) || (c == 16'h0013);
  endfunction

  function automatic logic is_prog_code(input logic [REG_W-1:0] c);
    return (c == 16'h0080) || (c == 16'h001A) || (c == 16'h001B);
  endfunction

  function automatic logic is_erase_code(input logic [REG_W-1:0] c);
    return (c == 16'h0065) || (c == 16'h0023) || (c == 16'h0071) ||
           (c == 16'h002A) || (c == 16'h002C);
  endfunction

  function automatic logic pin_level(input logic master, input logic pol);
    return master ? pol : ~pol;
  endfunction
endpackage

// File: rtl/fis_event_decode.sv
module fis_event_decode
  import flash_irq_pkg::*;
(
  input  logic               done_vld,
  input  logic [REG_W-1:0]   done_cmd,
  input  logic               load_done,
  output logic [NUM_SRC-1:0] ev_set
);
  always_comb begin
    ev_set            = '0;
    ev_set[IDX_LOAD]  = load_done | (done_vld & is_load_code(done_cmd));
    ev_set[IDX_PROG]  = done_vld & is_prog_code(done_cmd);
    ev_set[IDX_ERASE] = done_vld & is_erase_code(done_cmd);
    ev_set[IDX_RST]   = 1'b0;
  end
endmodule

// File: rtl/fis_src_flag.sv
module fis_src_flag #(
  parameter logic COLD_VAL = 1'b0,
  parameter logic WARM_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_req,
  input  logic warm_req,
  input  logic set_ev,
  input  logic clr_wr,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (cold_req)      q_nxt = COLD_VAL;
    else if (warm_req) q_nxt = WARM_VAL;
    else if (set_ev)   q_nxt = 1'b1;
    else if (clr_wr)   q_nxt = 1'b0;
    else               q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= COLD_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/fis_pin_drive.sv
module fis_pin_drive
  import flash_irq_pkg::*;
(
  input  logic master,
  input  logic pol,
  output logic pin
);
  assign pin = pin_level(master, pol);
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_vld,
  input  logic [REG_W-1:0] done_cmd,
  input  logic             load_done,
  input  logic             cold_req,
  input  logic             warm_req,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             int_pol,
  output logic [REG_W-1:0] rd_data,
  output logic             int_pin
);
  logic [NUM_SRC-1:0] ev_set;
  logic [NUM_SRC-1:0] clr_wr;
  logic [NUM_SRC-1:0] src_q;
  logic               master;

  fis_event_decode u_dec (
    .done_vld  (done_vld),
    .done_cmd  (done_cmd),
    .load_done (load_done),
    .ev_set    (ev_set)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    assign clr_wr[i] = wr_en & ~wr_data[SRC_LSB + i];
    fis_src_flag #(
      .COLD_VAL (COLD_DFLT[i]),
      .WARM_VAL (WARM_DFLT[i])
    ) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .cold_req (cold_req),
      .warm_req (warm_req),
      .set_ev   (ev_set[i]),
      .clr_wr   (clr_wr[i]),
      .q        (src_q[i])
    );
  end

  assign master = |src_q;

  always_comb begin
    rd_data                         = '0;
    rd_data[SRC_LSB +: NUM_SRC]     = src_q;
    rd_data[MASTER_BIT]             = master;
  end

  fis_pin_drive u_pin (
    .master (master),
    .pol    (int_pol),
    .pin    (int_pin)
  );
endmodule

// File: rtl/flash_irq_status_chk.sv
module flash_irq_status_chk
  import flash_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cold_req,
  input logic               warm_req,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic               int_pol,
  input logic [NUM_SRC-1:0] ev_set,
  input logic [REG_W-1:0]   rd_data,
  input logic               int_pin
);
  localparam logic [REG_W-1:0] RSV_MASK = 16'h7F0F;

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSV_MASK) == '0);

  // R9
  master_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[MASTER_BIT] == |rd_data[SRC_LSB +: NUM_SRC]);

  // R10
  pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pin == (rd_data[MASTER_BIT] ? int_pol : ~int_pol));

  // R8
  cold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cold_req |=> rd_data == 16'h8080);

  // R8
  warm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_req && !cold_req) |=> rd_data == 16'h8010);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set[IDX_PROG] && !cold_req && !warm_req) |=> rd_data[SRC_LSB + IDX_PROG]);

  // R2
  load_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set[IDX_LOAD] && !cold_req && !warm_req) |=> rd_data[SRC_LSB + IDX_LOAD]);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[SRC_LSB + IDX_ERASE] && !ev_set[IDX_ERASE] && !cold_req && !warm_req)
      |=> !rd_data[SRC_LSB + IDX_ERASE]);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ev_set == '0 && !cold_req && !warm_req) |=> $stable(rd_data));
endmodule

bind flash_irq_status flash_irq_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cold_req (cold_req),
  .warm_req (warm_req),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .int_pol  (int_pol),
  .ev_set   (ev_set),
  .rd_data  (rd_data),
  .int_pin  (int_pin)
);

// File: tb/tb_flash_irq_status.sv
module tb_flash_irq_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        done_vld, load_done, cold_req, warm_req, wr_en, int_pol;
  logic [15:0] done_cmd, wr_data, rd_data;
  logic        int_pin;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // model flags: [3]=load(bit7) [2]=prog(bit6) [1]=erase(bit5) [0]=reset(bit4)
  logic [3:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_irq_status dut (
    .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_cmd(done_cmd),
    .load_done(load_done), .cold_req(cold_req), .warm_req(warm_req),
    .wr_en(wr_en), .wr_data(wr_data), .int_pol(int_pol),
    .rd_data(rd_data), .int_pin(int_pin)
  );

  function automatic logic [3:0] cls_of(input logic v, input logic [15:0] c, input logic ld);
    logic [3:0] r = 4'b0000;
    if (ld) r[3] = 1'b1;
    if (v) begin
      case (c)
        16'h0000, 16'h0013:                            r[3] = 1'b1;
        16'h0080, 16'h001A, 16'h001B:                  r[2] = 1'b1;
        16'h0023, 16'h002A, 16'h002C, 16'h0065, 16'h0071: r[1] = 1'b1;
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic [15:0] word_of(input logic [3:0] f);
    return {(f != 4'b0000), 7'b0, f, 4'b0};
  endfunction

  function automatic logic exp_pin(input logic [3:0] f, input logic pol);
    if (f != 4'b0000) return pol;
    return !pol;
  endfunction

  task automatic check(input string tag);
    logic [15:0] ew = word_of(m_flags);
    logic        ep = exp_pin(m_flags, int_pol);
    n_tests++;
    if (rd_data !== ew || int_pin !== ep) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h pin=%b expected rd_data=%h pin=%b",
               tag, rd_data, int_pin, ew, ep);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [15:0] c,
                      input logic ld, input logic we, input logic [15:0] wd,
                      input logic cr, input logic wr, input logic pol);
    logic [3:0] ev;
    @(negedge clk);
    done_vld = v; done_cmd = c; load_done = ld; wr_en = we; wr_data = wd;
    cold_req = cr; warm_req = wr; int_pol = pol;
    ev = cls_of(v, c, ld);
    if (cr)      m_flags = 4'b1000;
    else if (wr) m_flags = 4'b0001;
    else begin
      for (int i = 0; i < 4; i++) begin
        if (ev[i])                m_flags[i] = 1'b1;
        else if (we && !wd[4+i])  m_flags[i] = 1'b0;
      end
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(tag);
  endtask

  task automatic idle(input string tag, input logic pol);
    step(tag, 1'b0, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, pol);
  endtask

  function automatic logic [15:0] pick_cmd();
    logic [15:0] lst [12] = '{16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
                              16'h0023, 16'h002A, 16'h002C, 16'h0065, 16'h0071,
                              16'h0081, 16'h0012};
    if ($urandom_range(0, 3) == 0) return 16'($urandom);
    return lst[$urandom_range(0, 11)];
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; done_vld = 0; done_cmd = 0; load_done = 0; cold_req = 0;
    warm_req = 0; wr_en = 0; wr_data = 0; int_pol = 1'b1;
    m_flags = 4'b1000;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1 after release");

    step("R6 clear load flag", 0, 16'h0, 0, 1, 16'hFF7F, 0, 0, 1);
    step("R6 write ones no effect", 0, 16'h0, 0, 1, 16'hFFFF, 0, 0, 1);
    step("R7 reserved writes ignored", 0, 16'h0, 0, 1, 16'h7F0F, 0, 0, 1);
    step("R2 code 0013h", 1, 16'h0013, 0, 0, 16'h0, 0, 0, 1);
    step("R6 clear", 0, 16'h0, 0, 1, 16'h0000, 0, 0, 1);
    step("R2 code 0000h", 1, 16'h0000, 0, 0, 16'h0, 0, 0, 1);
    step("R6 clear", 0, 16'h0, 0, 1, 16'h0000, 0, 0, 1);
    step("R2 buffer load strobe", 0, 16'h0, 1, 0, 16'h0, 0, 0, 1);
    step("R6 clear", 0, 16'h0, 0, 1, 16'h0000, 0, 0, 1);
    step("R3 code 001Ah", 1, 16'h001A, 0, 0, 16'h0, 0, 0, 1);
    step("R4 code 002Ch", 1, 16'h002C, 0, 0, 16'h0, 0, 0, 1);
    step("R9 write 0 to master", 0, 16'h0, 0, 1, 16'h7FFF, 0, 0, 1);
    step("R10 polarity low", 0, 16'h0, 0, 0, 16'h0, 0, 0, 0);
    step("R5 unlisted code 0081h", 1, 16'h0081, 0, 0, 16'h0, 0, 0, 0);
    step("R5 unlisted code 0012h", 1, 16'h0012, 0, 0, 16'h0, 0, 0, 0);
    step("R11 set beats clear", 1, 16'h0080, 0, 1, 16'h0000, 0, 0, 0);
    step("R6 clear all", 0, 16'h0, 0, 1, 16'h0000, 0, 0, 0);
    step("R10 idle pin level", 0, 16'h0, 0, 0, 16'h0, 0, 0, 1);
    step("R3 code 001Bh", 1, 16'h001B, 0, 0, 16'h0, 0, 0, 1);
    step("R8 warm request", 0, 16'h0, 0, 0, 16'h0, 0, 1, 1);
    step("R8 cold and warm together", 0, 16'h0, 0, 0, 16'h0, 1, 1, 1);
    step("R12 warm over event and write", 1, 16'h0065, 0, 1, 16'h0000, 0, 1, 1);
    step("R12 cold over event and write", 1, 16'h001A, 0, 1, 16'h0000, 1, 0, 0);
    step("R4 code 0071h", 1, 16'h0071, 0, 0, 16'h0, 0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      logic v  = ($urandom_range(0, 2) != 0);
      logic ld = ($urandom_range(0, 9) == 0);
      logic we = ($urandom_range(0, 3) == 0);
      logic cr = ($urandom_range(0, 63) == 0);
      logic wr = ($urandom_range(0, 63) == 0);
      step("random mix", v, pick_cmd(), ld, we, 16'($urandom), cr, wr,
           1'($urandom_range(0, 1)));
    end
    idle("R9 final idle", 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule